// File: doc/BRIEF.md
# Mixed-Sign Fractional/Integer Multiplier

This block multiplies two 16-bit operands in a single registered stage. Each operand has its own signedness flag. A signed operand is widened to 17 bits by copying its top bit, and an unsigned operand is widened by adding a zero. Because of this, signed-by-signed, signed-by-unsigned and unsigned-by-unsigned products all come from one 17x17 signed multiply.

A mode select chooses how the product is read. In integer mode the low 32 bits of the product are the answer. In fractional mode both operands are treated as 1.15 values. The 2.30 product is then moved up one place, with a zero entering the least significant bit, so it reads as 1.31. Finally a 40-bit copy of the result is formed so it can feed a wide accumulator datapath. That copy carries the sign of the full product, so the fractional product of -1.0 and -1.0 appears as +1.0 and not as a negative value.

An input valid strobe marks the cycles that carry operands. A matching output valid follows one cycle later. There is no back-pressure.

Top module: `mixed_mul`

## Requirements
- R1: Each operand is widened to 17 bits before the multiply. A signed operand (flag 1) is sign-extended and an unsigned operand (flag 0) is zero-extended. Each flag acts on its own operand only.
- R2: With `fracMode` = 0, `result` equals the low 32 bits of the exact product of the widened operands.
- R3: With `fracMode` = 1, `result` equals the exact product shifted left by one bit, truncated to 32 bits. Bit 0 of `result` is then always 0.
- R4: With `fracMode` = 1 and both operands signed, the inputs 0x8000 and 0x8000 give `result` = 0x8000_0000 and `resultExt` = 0x00_8000_0000.
- R5: When at least one operand is signed, `resultExt` is the shifted (or unshifted) full product sign-extended to 40 bits. Bits 39..33 are then all equal.
- R6: When both operands are unsigned, `resultExt[39:32]` is zero and `resultExt[31:0]` equals `result`.
- R7: `outValid` is high in the cycle after a cycle with `inValid` high, and low after a cycle with `inValid` low. The results for an accepted operand pair appear together with that `outValid`.
- R8: A synchronous active-high `rst` clears `outValid`, `result` and `resultExt` to zero at the next clock edge.
- R9: While `inValid` is low, `result` and `resultExt` keep their previous values whatever the operand, flag and mode inputs do.
- R10: The one-bit scaling of R3 is applied in fractional mode even when one or both operands are unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| aSigned | input | 1 | 1: opA is signed, 0: opA is unsigned |
| bSigned | input | 1 | 1: opB is signed, 0: opB is unsigned |
| fracMode | input | 1 | 1: fractional (scale by two), 0: integer |
| outValid | output | 1 | Results are valid |
| result | output | 32 | Integer or 1.31 fractional product |
| resultExt | output | 40 | Result extended to 40 bits |

## Verification
Every result is due exactly one rising edge after the edge that samples `inValid` high. The bench drives each operand pair on a falling edge and compares `outValid`, `result` and `resultExt` on the next falling edge, one cycle later. The hold and reset checks follow the same pattern. The bench changes the inputs with `inValid` or `rst` set, lets one rising edge pass, and reads the ports half a cycle after that edge.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // capture a new product this edge
    logic clearAll;   // synchronous clear of the result registers
  } mulStrobes_t;

endpackage

// File: rtl/mul_operand_widen.sv
module mul_operand_widen #(
  parameter int IN_W = 16
) (
  input  logic                    isSigned,
  input  logic [IN_W-1:0]         opIn,
  output logic signed [IN_W:0]    opWide
);

  logic topBit;

  always_comb begin
    topBit = isSigned & opIn[IN_W-1];
    opWide = {topBit, opIn};
  end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output mulStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.loadEn   = inValid & ~rst;
    strobes.clearAll = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 40
) (
  input  logic                  clk,
  input  mulStrobes_t           strobes,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  input  logic                  aSigned,
  input  logic                  bSigned,
  input  logic                  fracMode,
  output logic [2*DATA_W-1:0]   result,
  output logic [EXT_W-1:0]      resultExt
);

  localparam int WIDE_W  = DATA_W + 1;
  localparam int PROD_W  = 2 * WIDE_W;
  localparam int SCL_W   = PROD_W + 1;
  localparam int RES_W   = 2 * DATA_W;
  localparam int GUARD_W = EXT_W - RES_W;
  localparam int SEXT_W  = EXT_W - SCL_W;

  logic signed [WIDE_W-1:0] wideOp [2];
  logic [DATA_W-1:0]        rawOp  [2];
  logic                     sgnOp  [2];

  always_comb begin
    rawOp[0] = opA;
    rawOp[1] = opB;
    sgnOp[0] = aSigned;
    sgnOp[1] = bSigned;
  end

  for (genvar i = 0; i < 2; i++) begin : g_widen
    mul_operand_widen #(.IN_W(DATA_W)) u_widen (
      .isSigned (sgnOp[i]),
      .opIn     (rawOp[i]),
      .opWide   (wideOp[i])
    );
  end

  logic signed [PROD_W-1:0] product;
  logic signed [SCL_W-1:0]  scaled;
  logic                     anySigned;
  logic [EXT_W-1:0]         extNext;

  always_comb begin
    product   = wideOp[0] * wideOp[1];
    scaled    = fracMode ? {product, 1'b0} : {product[PROD_W-1], product};
    anySigned = aSigned | bSigned;
    if (anySigned) extNext = {{SEXT_W{scaled[SCL_W-1]}}, scaled};
    else           extNext = {{GUARD_W{1'b0}}, scaled[RES_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      result    <= '0;
      resultExt <= '0;
    end else if (strobes.loadEn) begin
      result    <= scaled[RES_W-1:0];
      resultExt <= extNext;
    end
  end

endmodule

// File: rtl/mixed_mul.sv
module mixed_mul
  import mul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic                aSigned,
  input  logic                bSigned,
  input  logic                fracMode,
  output logic                outValid,
  output logic [2*DATA_W-1:0] result,
  output logic [EXT_W-1:0]    resultExt
);

  mulStrobes_t strobes;

  mul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  mul_datapath #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .aSigned   (aSigned),
    .bSigned   (bSigned),
    .fracMode  (fracMode),
    .result    (result),
    .resultExt (resultExt)
  );

endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 40
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic                aSigned,
  input logic                bSigned,
  input logic                fracMode,
  input logic                outValid,
  input logic [2*DATA_W-1:0] result,
  input logic [EXT_W-1:0]    resultExt
);

  localparam int RES_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [EXT_W-1:0]  PLUS_ONE = {{(EXT_W-RES_W){1'b0}}, 1'b1, {(RES_W-1){1'b0}}};

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_frac_lsb_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && fracMode) |=> (result[0] == 1'b0));

  assert_minus_one_squared_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && fracMode && aSigned && bSigned && opA == MIN_NEG && opB == MIN_NEG)
      |=> (resultExt == PLUS_ONE));

  assert_upper_consistent_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && (aSigned || bSigned))
      |=> (resultExt[EXT_W-1:RES_W+1] == '0 || resultExt[EXT_W-1:RES_W+1] == '1));

  assert_unsigned_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && !aSigned && !bSigned)
      |=> (resultExt[EXT_W-1:RES_W] == '0 && resultExt[RES_W-1:0] == result));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(result) && $stable(resultExt)));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0 && resultExt == '0));

endmodule

bind mixed_mul mul_checker #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .opA       (opA),
  .opB       (opB),
  .aSigned   (aSigned),
  .bSigned   (bSigned),
  .fracMode  (fracMode),
  .outValid  (outValid),
  .result    (result),
  .resultExt (resultExt)
);

// File: tb/tb_mixed_mul.sv
module tb_mixed_mul;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [15:0] opA, opB;
  logic        aSigned, bSigned, fracMode;
  logic        outValid;
  logic [31:0] result;
  logic [39:0] resultExt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mixed_mul dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .fracMode(fracMode),
    .outValid(outValid), .result(result), .resultExt(resultExt)
  );

  // {opA, opB, aSigned, bSigned, fracMode, expected result, expected resultExt}
  localparam int NV = 14;
  localparam logic [106:0] VEC [NV] = '{
    {16'h1234, 16'h0010, 3'b110, 32'h0001_2340, 40'h00_0001_2340},
    {16'hFFFF, 16'h0002, 3'b110, 32'hFFFF_FFFE, 40'hFF_FFFF_FFFE},
    {16'hFFFF, 16'hFFFF, 3'b100, 32'hFFFF_0001, 40'hFF_FFFF_0001}, // R1 signed x unsigned
    {16'h8000, 16'hFFFF, 3'b010, 32'hFFFF_8000, 40'hFF_FFFF_8000}, // R1 unsigned x signed
    {16'hFFFF, 16'hFFFF, 3'b000, 32'hFFFE_0001, 40'h00_FFFE_0001},
    {16'h8000, 16'h8000, 3'b110, 32'h4000_0000, 40'h00_4000_0000},
    {16'h8000, 16'h7FFF, 3'b110, 32'hC000_8000, 40'hFF_C000_8000},
    {16'h0000, 16'h8000, 3'b110, 32'h0000_0000, 40'h00_0000_0000},
    {16'h4000, 16'h4000, 3'b111, 32'h2000_0000, 40'h00_2000_0000},
    {16'h8000, 16'h4000, 3'b111, 32'hC000_0000, 40'hFF_C000_0000},
    {16'h8000, 16'h8000, 3'b111, 32'h8000_0000, 40'h00_8000_0000}, // R4
    {16'h7FFF, 16'h7FFF, 3'b111, 32'h7FFE_0002, 40'h00_7FFE_0002},
    {16'hFFFF, 16'hFFFF, 3'b001, 32'hFFFC_0002, 40'h00_FFFC_0002}, // R10
    {16'hFFFF, 16'h0002, 3'b101, 32'hFFFF_FFFC, 40'hFF_FFFF_FFFC}  // R10
  };

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                       input logic as, input logic bs, input logic fr);
    inValid = v; opA = a; opB = b; aSigned = as; bSigned = bs; fracMode = fr;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R8: state after reset
    check("R8 outValid", {39'd0, outValid}, 40'd0);
    check("R8 result", {8'd0, result}, 40'd0);
    check("R8 resultExt", resultExt, 40'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [106:0] v;
      string t32, t40;
      v = VEC[i];
      drive(1'b1, v[106:91], v[90:75], v[74], v[73], v[72]);
      @(negedge clk);
      if (v[72] && v[106:91] == 16'h8000 && v[90:75] == 16'h8000 && v[74] && v[73])
        t32 = "R4";
      else if (v[72] && !(v[74] && v[73])) t32 = "R10";
      else if (v[72]) t32 = "R3";
      else if (v[74] != v[73]) t32 = "R1";
      else t32 = "R2";
      t40 = (v[74] || v[73]) ? "R5" : "R6";
      check("R7 outValid", {39'd0, outValid}, 40'd1);
      check({t32, " result"}, {8'd0, result}, {8'd0, v[71:40]});
      check({t40, " resultExt"}, resultExt, v[39:0]);
    end

    // R9 / R7: idle cycle with changing inputs must not disturb results
    drive(1'b0, 16'h1111, 16'h2222, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 idle outValid", {39'd0, outValid}, 40'd0);
    check("R9 hold result", {8'd0, result}, 40'h00_FFFF_FFFC);
    check("R9 hold resultExt", resultExt, 40'hFF_FFFF_FFFC);
    drive(1'b0, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R9 hold resultExt again", resultExt, 40'hFF_FFFF_FFFC);

    // back-to-back accepts: second result must replace the first
    drive(1'b1, 16'h0003, 16'h0005, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 b2b first", {8'd0, result}, 40'h00_0000_000F);
    drive(1'b1, 16'h0003, 16'h0005, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R10 b2b second", {8'd0, result}, 40'h00_0000_001E);

    // R8: reset during operation, even with inValid high
    rst = 1'b1;
    drive(1'b1, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 mid reset outValid", {39'd0, outValid}, 40'd0);
    check("R8 mid reset resultExt", resultExt, 40'd0);
    rst = 1'b0;
    drive(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule